// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the bytes of an incoming Ethernet frame and decides whether the frame is kept or thrown away, based on the 48-bit destination address in its first six bytes. It has three tests. The first compares the address with two programmable station addresses, each with its own enable. The second accepts the all-ones broadcast address when that is enabled. The third looks the address up in a 64-bit group hash table that works as a single-hash Bloom filter. The hash index is the XOR of the eight 6-bit slices of the address, with the bits taken in the order they appear on the wire. A small 32-bit register port holds the station addresses, the hash table and a control word.

Frame bytes arrive on a valid/ready stream with start and end markers. The block never applies back-pressure: `in_ready` is held high, and a byte is taken on every cycle where `in_valid` is high. A cycle with `in_valid` low carries nothing, whatever the other stream pins show. The block gives exactly one registered verdict strobe per frame. A frame that fails every address test is dropped on the cycle after its sixth byte, and its remaining bytes are ignored. Any other frame gets its verdict on the cycle after its last byte, once its length and the state of the downstream buffer are known.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset every register reads zero, no verdict is pending, and every frame is dropped because all filters are off.
- R2: The registers sit at these byte offsets: station 0 low/high at 0x00/0x04, station 1 low/high at 0x08/0x0C, hash table low/high at 0x10/0x14, control at 0x1C. A read returns the last full 32-bit value written. Other offsets read zero and ignore writes.
- R3: A station address is built with low-word bits [7:0] as destination byte 0 (the first byte on the wire), up to low bits [31:24] as byte 3, then high bits [7:0] as byte 4 and [15:8] as byte 5. Control bit 0 enables station 0 and bit 1 enables station 1. An enabled station whose value equals the destination passes the frame.
- R4: With control bit 3 set, a destination of all ones passes. With bit 3 clear, it passes only through another test.
- R5: The hash index bit k is the XOR of destination stream bits k, k+6, …, k+42, where stream bit i is bit i%8 of byte i/8. Index 0–31 selects that bit of the low table word, and 32–63 selects bit (index−32) of the high word. A set bit passes the frame. With control bit 2 clear, only destinations with byte 0 bit 0 set may use the table.
- R6: A frame that passes no test gets a drop verdict one cycle after its sixth byte is taken. Its later bytes, up to the next start marker, produce no verdict.
- R7: A frame of fewer than 12 bytes is dropped, with the verdict one cycle after its end byte. A frame with a passing address and 12 or more bytes is accepted on the cycle after its end byte.
- R8: A frame with a passing address and more than 1536 bytes gets the error flag instead of accept.
- R9: A frame with a passing address whose end byte is taken while `buf_busy` is high gets the error flag instead of accept.
- R10: The configuration is captured when the start byte is taken. A register write made after that point applies from the next frame.
- R11: Each frame gets exactly one verdict. `verdict_accept` and `verdict_error` are never both high, and both are low when `verdict_valid` is low.
- R12: `in_ready` is always high, and cycles with `in_valid` low are ignored, including any end marker shown on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte present |
| in_ready | output | 1 | Always high; no back-pressure |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| buf_busy | input | 1 | Downstream receive buffer still occupied |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Frame accepted |
| verdict_error | output | 1 | Frame would pass but is too long or the buffer is busy |

## Verification
The filter is driven with destinations that agree with a station address in all but the last byte. This separates an exact match from a partial one and also tests the byte order of the assembled address. Two group destinations whose hashes fall in different table words test the index arithmetic. Individual destinations that hash onto a set bit show the effect of the group-only gate. Frame lengths of 4, 11, 12, 1536 and 1537 bytes, idle gaps that carry a stray end marker, a control write made mid-frame, and back-to-back one-byte frames separate the address verdict from the end-of-frame verdict and pin the cycle of each.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int MAC_W   = 48;
  localparam int HASH_W  = 6;
  localparam int TBL_W   = 1 << HASH_W;
  localparam int NUM_ST  = 2;
  localparam int REG_AW  = 8;
  localparam int REG_DW  = 32;

  localparam logic [REG_AW-1:0] OFS_ST_BASE = 8'h00;
  localparam logic [REG_AW-1:0] OFS_TBL_LO  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_TBL_HI  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_CTL     = 8'h1C;

  typedef struct packed {
    logic [NUM_ST-1:0][MAC_W-1:0] station;
    logic [NUM_ST-1:0]            st_en;
    logic [TBL_W-1:0]             grp_tbl;
    logic                         grp_any;
    logic                         bc_en;
  } filt_cfg_t;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output filt_cfg_t         cfg_o
);
  logic [REG_DW-1:0] st_lo [NUM_ST];
  logic [REG_DW-1:0] st_hi [NUM_ST];
  logic [REG_DW-1:0] tbl_lo, tbl_hi, ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_ST; s++) begin
        st_lo[s] <= '0;
        st_hi[s] <= '0;
      end
      tbl_lo <= '0;
      tbl_hi <= '0;
      ctl    <= '0;
    end else if (we_i) begin
      for (int s = 0; s < NUM_ST; s++) begin
        if (addr_i == OFS_ST_BASE + REG_AW'(8*s))     st_lo[s] <= wdata_i;
        if (addr_i == OFS_ST_BASE + REG_AW'(8*s + 4)) st_hi[s] <= wdata_i;
      end
      if (addr_i == OFS_TBL_LO) tbl_lo <= wdata_i;
      if (addr_i == OFS_TBL_HI) tbl_hi <= wdata_i;
      if (addr_i == OFS_CTL)    ctl    <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NUM_ST; s++) begin
      if (addr_i == OFS_ST_BASE + REG_AW'(8*s))     rdata_o = st_lo[s];
      if (addr_i == OFS_ST_BASE + REG_AW'(8*s + 4)) rdata_o = st_hi[s];
    end
    if (addr_i == OFS_TBL_LO) rdata_o = tbl_lo;
    if (addr_i == OFS_TBL_HI) rdata_o = tbl_hi;
    if (addr_i == OFS_CTL)    rdata_o = ctl;
  end

  always_comb begin
    for (int s = 0; s < NUM_ST; s++) begin
      cfg_o.station[s] = {st_hi[s][MAC_W-REG_DW-1:0], st_lo[s]};
      cfg_o.st_en[s]   = ctl[s];
    end
    cfg_o.grp_tbl = {tbl_hi, tbl_lo};
    cfg_o.grp_any = ctl[2];
    cfg_o.bc_en   = ctl[3];
  end

  // R2: a table write is visible in the stored table on the next cycle
  p_tbl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == OFS_TBL_LO) |=> (cfg_o.grp_tbl[REG_DW-1:0] == $past(wdata_i)));
endmodule

// File: rtl/rxf_hash.sv
module rxf_hash
  import rxf_pkg::*;
(
  input  logic [MAC_W-1:0]  addr_i,
  input  logic [TBL_W-1:0]  tbl_i,
  output logic [HASH_W-1:0] idx_o,
  output logic              hit_o
);
  localparam int NCH   = (MAC_W + HASH_W - 1) / HASH_W;
  localparam int PAD_W = NCH * HASH_W;

  logic [PAD_W-1:0]  padded;
  logic [HASH_W-1:0] chunk [NCH];

  assign padded = PAD_W'(addr_i);

  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    assign chunk[c] = padded[c*HASH_W +: HASH_W];
  end

  always_comb begin
    idx_o = '0;
    for (int c = 0; c < NCH; c++) idx_o = idx_o ^ chunk[c];
  end

  assign hit_o = tbl_i[idx_o];
endmodule

// File: rtl/rxf_match.sv
module rxf_match
  import rxf_pkg::*;
(
  input  filt_cfg_t        cfg_i,
  input  logic [MAC_W-1:0] dest_i,
  output logic             hit_o
);
  logic [NUM_ST-1:0] st_hit;
  logic              bc_hit, grp_gate, tbl_hit;
  logic [HASH_W-1:0] hidx;

  for (genvar s = 0; s < NUM_ST; s++) begin : g_st
    assign st_hit[s] = cfg_i.st_en[s] && (dest_i == cfg_i.station[s]);
  end

  assign bc_hit   = cfg_i.bc_en && (&dest_i);
  assign grp_gate = cfg_i.grp_any || dest_i[0];

  rxf_hash u_hash (
    .addr_i (dest_i),
    .tbl_i  (cfg_i.grp_tbl),
    .idx_o  (hidx),
    .hit_o  (tbl_hit)
  );

  assign hit_o = (|st_hit) || bc_hit || (grp_gate && tbl_hit);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int MAX_LEN = 1536,
  parameter int MIN_LEN = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              buf_busy,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              verdict_valid,
  output logic              verdict_accept,
  output logic              verdict_error
);
  localparam int ADDR_BYTES = MAC_W / 8;
  localparam int LAST_AB    = ADDR_BYTES - 1;
  localparam int SAT        = MAX_LEN + 1;
  localparam int CW         = $clog2(SAT + 1);

  filt_cfg_t cfg_live, cfg_snap, cfg_use;
  logic [LAST_AB-1:0][7:0] abuf;
  logic [CW-1:0] cnt, idx, len;
  logic          in_frame, addr_ok;
  logic          take, at_dec, addr_hit, pass;
  logic          vld_d, acc_d, err_d;

  assign in_ready = 1'b1;

  rxf_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata),
    .cfg_o   (cfg_live)
  );

  assign take    = in_valid && (in_sof || in_frame);
  assign idx     = in_sof ? '0 : cnt;
  assign len     = (idx == CW'(SAT)) ? CW'(SAT) : idx + CW'(1);
  assign cfg_use = in_sof ? cfg_live : cfg_snap;
  assign at_dec  = take && (idx == CW'(LAST_AB));

  rxf_match u_match (
    .cfg_i  (cfg_use),
    .dest_i ({in_data, abuf}),
    .hit_o  (addr_hit)
  );

  assign pass = at_dec ? addr_hit : ((idx > CW'(LAST_AB)) && addr_ok);

  always_comb begin
    vld_d = 1'b0;
    acc_d = 1'b0;
    err_d = 1'b0;
    if (take && in_eof) begin
      vld_d = 1'b1;
      if (pass && len >= CW'(MIN_LEN)) begin
        if (len > CW'(MAX_LEN) || buf_busy) err_d = 1'b1;
        else                                acc_d = 1'b1;
      end
    end else if (at_dec && !addr_hit) begin
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      addr_ok  <= 1'b0;
      cnt      <= '0;
      abuf     <= '0;
      cfg_snap <= '0;
    end else if (take) begin
      cnt      <= len;
      in_frame <= !in_eof && !(at_dec && !addr_hit);
      if (in_sof) cfg_snap <= cfg_live;
      if (idx < CW'(LAST_AB)) abuf[idx[2:0]] <= in_data;
      if (at_dec) addr_ok <= addr_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict_accept <= 1'b0;
      verdict_error  <= 1'b0;
    end else begin
      verdict_valid  <= vld_d;
      verdict_accept <= acc_d;
      verdict_error  <= err_d;
    end
  end

  // R11: accept and error are exclusive
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> !(verdict_accept && verdict_error));
  // R11: flags are low without a strobe
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> (!verdict_accept && !verdict_error));
  // R7: acceptance follows an end byte
  p_acc_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_accept) |-> $past(in_valid && in_eof));
  // R8: error flag follows an end byte
  p_err_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_error) |-> $past(in_valid && in_eof));
  // R6: every verdict follows a taken byte
  p_vld_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(in_valid));
endmodule

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, buf_busy = 1'b0;
  logic [7:0] in_data = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic in_ready, verdict_valid, verdict_accept, verdict_error;

  always #4 clk = ~clk;

  rx_dest_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .buf_busy(buf_busy),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .verdict_valid(verdict_valid),
    .verdict_accept(verdict_accept), .verdict_error(verdict_error)
  );

  typedef struct { bit acc; bit err; int cyc; string req; } exp_t;
  exp_t expq[$];
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  logic [47:0] m_st [2];
  logic [63:0] m_tbl = '0;
  logic [31:0] m_ctl = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (verdict_valid) begin
        if (expq.size() == 0) begin
          chk(0, "R11", "unexpected verdict", {verdict_accept, verdict_error}, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(e.cyc == cyc, e.req, "verdict cycle", cyc, e.cyc);
          chk(verdict_accept == e.acc && verdict_error == e.err, e.req,
              "accept/error", {verdict_accept, verdict_error}, {e.acc, e.err});
        end
      end else if (expq.size() != 0 && expq[0].cyc <= cyc) begin
        chk(0, expq[0].req, "missing verdict", 0, expq[0].cyc);
        void'(expq.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R11", "watchdog expired", 0, 1);
    finish_run();
  end

  function automatic logic [5:0] href(input logic [47:0] a);
    logic [5:0] h = '0;
    for (int i = 0; i < 48; i++) if (a[i]) h[i % 6] = h[i % 6] ^ 1'b1;
    return h;
  endfunction

  function automatic bit amatch(input logic [47:0] d);
    bit m = 0;
    for (int s = 0; s < 2; s++) if (m_ctl[s] && d == m_st[s]) m = 1;
    if (m_ctl[3] && d == '1) m = 1;
    if ((m_ctl[2] || d[0]) && m_tbl[href(d)]) m = 1;
    return m;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a == 8'h10) m_tbl[31:0] = d;
    if (a == 8'h14) m_tbl[63:32] = d;
    if (a == 8'h1C) m_ctl = d;
  endtask

  task automatic set_st(input int s, input logic [47:0] a);
    wr(8'(8*s), a[31:0]);
    wr(8'(8*s + 4), {16'h0, a[47:32]});
    m_st[s] = a;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == e, req, "register read", reg_rdata, e);
  endtask

  task automatic send(input logic [47:0] dest, input int len, input bit busy,
                      input int gap_at, input int mw_at, input logic [31:0] mw_ctl,
                      input string req);
    bit m, acc, err;
    int dec;
    exp_t e;
    m = amatch(dest);
    acc = 0; err = 0;
    if (len < 6) dec = len - 1;
    else if (!m) dec = 5;
    else begin
      dec = len - 1;
      if (len >= 12) begin
        if (len > 1536 || busy) err = 1; else acc = 1;
      end
    end
    buf_busy = busy;
    for (int i = 0; i < len; i++) begin
      if (i == gap_at) begin
        in_valid = 0; in_sof = 0; in_eof = 1; in_data = 8'hFF;
        @(negedge clk);
      end
      in_valid = 1;
      in_sof = (i == 0);
      in_eof = (i == len - 1);
      in_data = (i < 6) ? dest[8*i +: 8] : 8'(i);
      if (i == mw_at) begin reg_we = 1; reg_addr = 8'h1C; reg_wdata = mw_ctl; end
      if (i == dec) begin
        e.acc = acc; e.err = err; e.cyc = cyc + 1; e.req = req;
        expq.push_back(e);
      end
      @(negedge clk);
      reg_we = 0;
    end
    in_valid = 0; in_sof = 0; in_eof = 0; buf_busy = 0;
    if (mw_at >= 0 && mw_at < len) m_ctl = mw_ctl;
  endtask

  initial begin
    logic [47:0] st0, st1;
    st0 = 48'h6655_4433_2211;
    st1 = 48'h0A0B_0C0D_0E0F;
    m_st[0] = '0; m_st[1] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    rd_chk(8'h00, 0, "R1"); rd_chk(8'h14, 0, "R1"); rd_chk(8'h1C, 0, "R1");
    chk(verdict_valid == 0, "R1", "no verdict after reset", verdict_valid, 0);
    chk(in_ready == 1, "R12", "ready high", in_ready, 1);
    send('1, 20, 0, -1, -1, 0, "R1");
    // R2: map and readback
    set_st(0, st0);
    set_st(1, st1);
    wr(8'h18, 32'hDEAD_BEEF);
    rd_chk(8'h00, 32'h4433_2211, "R2"); rd_chk(8'h04, 32'h0000_6655, "R2");
    rd_chk(8'h08, 32'h0C0D_0E0F, "R2"); rd_chk(8'h18, 32'h0, "R2");
    // R3: station filters
    wr(8'h1C, 32'h1);
    rd_chk(8'h1C, 32'h1, "R2");
    send(st0, 64, 0, -1, -1, 0, "R3");
    send(st0 ^ 48'h0100_0000_0000, 64, 0, -1, -1, 0, "R6");
    send(st1, 30, 0, -1, -1, 0, "R3");
    wr(8'h1C, 32'h2);
    send(st1, 30, 0, -1, -1, 0, "R3");
    send(st0, 30, 0, -1, -1, 0, "R3");
    // R4: broadcast
    send('1, 40, 0, -1, -1, 0, "R4");
    wr(8'h1C, 32'h8);
    send('1, 40, 0, -1, -1, 0, "R4");
    // R5: hash table, both words and group gate
    wr(8'h1C, 32'h0);
    wr(8'h10, 32'h0000_0008);
    wr(8'h14, 32'h0000_0006);
    send(48'h21, 20, 0, -1, -1, 0, "R5");
    send(48'h03, 20, 0, -1, -1, 0, "R5");
    send(48'h23, 20, 0, -1, -1, 0, "R5");
    send(48'h22, 20, 0, -1, -1, 0, "R5");
    wr(8'h1C, 32'h4);
    send(48'h22, 20, 0, -1, -1, 0, "R5");
    // R7: lengths
    wr(8'h1C, 32'h1);
    send(st0, 11, 0, -1, -1, 0, "R7");
    send(st0, 12, 0, -1, -1, 0, "R7");
    send(st0, 4, 0, -1, -1, 0, "R7");
    // R8: length limit
    send(st0, 1536, 0, -1, -1, 0, "R8");
    send(st0, 1537, 0, -1, -1, 0, "R8");
    // R9: busy buffer
    send(st0, 20, 1, -1, -1, 0, "R9");
    // R10: mid-frame write applies next frame
    send(st0, 20, 0, -1, 3, 32'h0, "R10");
    send(st0, 20, 0, -1, -1, 0, "R10");
    // R12: idle gaps with stray end marker
    wr(8'h1C, 32'h1);
    send(st0, 16, 0, 2, -1, 0, "R12");
    send(st0, 16, 0, 9, -1, 0, "R12");
    // R11: back-to-back one-byte frames
    send(st0, 1, 0, -1, -1, 0, "R11");
    send(st0, 1, 0, -1, -1, 0, "R11");
    send(st0, 13, 0, -1, -1, 0, "R11");
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R11", "all verdicts seen", expq.size(), 0);
    done = 1;
    finish_run();
  end
endmodule